// File: doc/BRIEF.md
# Interrupt Source Capture Unit

This block sits between a bank of raw interrupt lines and whatever priority and routing logic follows. Each source line passes through a reset-cleared synchroniser. A per-source detector, set by two configuration bits, then decides whether the line raised an event. Events set a sticky pending bit. A separate per-source enable bit gates which pending sources reach the `active_o` vector handed downstream.

Software changes state through a single write port. Some operations name one source by number in `wr_data`, so one bit can be acknowledged, enabled or disabled without a read-modify-write. Other operations act on a 32-source group chosen by `wr_grp` and clear every bit that is 1 in `wr_data`. The same group addressing loads the polarity word and the detection-kind word.

Top module: `irq_src_capture`

## Requirements
- R1: During reset `pend_o`, `en_o` and `active_o` are zero. Polarity, kind and all synchroniser stages also reset to zero. All-zero configuration means active-low level detection, so every source becomes pending within SYNC_STAGES+1 clock edges after reset is released.
- R2: With kind=1 and polarity=1, a 0-to-1 change of a source sets its pending bit. A 1-to-0 change or a steady level sets nothing.
- R3: With kind=1 and polarity=0, a 1-to-0 change sets the pending bit and a 0-to-1 change does not.
- R4: With kind=0 and polarity=1, a high input sets the pending bit and a low input does not.
- R5: With kind=0 and polarity=0, a low input sets the pending bit and a high input does not.
- R6: A level source re-captures in every cycle its input is active, so an acknowledge has no effect while it stays active. Once the input is inactive the bit stays set until acknowledged, and an acknowledge then clears it.
- R7: Op 1 (acknowledge) clears the pending bit of the source whose number is in `wr_data` and no other bit.
- R8: Op 2 sets and op 3 clears the enable bit of the source numbered by `wr_data`, ignoring `wr_grp`. `active_o` is `pend_o & en_o`.
- R9: Op 4 (pending wipe) and op 5 (enable wipe) clear, for each bit b that is 1 in `wr_data`, source 32*`wr_grp`+b. Sources in other groups are untouched.
- R10: When a capture and a clear of the same pending bit fall in the same cycle, the bit ends set.
- R11: An index operation whose `wr_data` is at least NUM_SRC changes nothing, and op 0 changes nothing.
- R12: A source change reaches `pend_o` exactly SYNC_STAGES+1 rising edges after it is applied (3 by default).
- R13: Op 6 loads the polarity bits and op 7 loads the kind bits: bit b of `wr_data` goes to source 32*`wr_grp`+b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Raw interrupt lines, asynchronous |
| wr_en | input | 1 | Write strobe, one operation per cycle |
| wr_op | input | 3 | Operation code (0 none, 1 ack, 2 enable set, 3 enable clear, 4 pending wipe, 5 enable wipe, 6 polarity load, 7 kind load) |
| wr_grp | input | GRP_IDX_W | Group of 32 sources for wipe and load operations |
| wr_data | input | 32 | Source number or group bit mask |
| pend_o | output | NUM_SRC | Pending bits |
| en_o | output | NUM_SRC | Enable bits |
| active_o | output | NUM_SRC | Pending and enabled sources |

## Verification
The bench goes after the collision of a capture with an acknowledge in the same edge. A design that let the clear win would silently drop that interrupt. It checks that an acknowledge of an active level source does not stick, since a design that honoured it would report a quiet line that is still asserted. It counts the synchroniser latency edge by edge and checks that edge detectors ignore the opposite transition and steady levels. It also checks that group wipes land only in the group named by `wr_grp` and that out-of-range indices leave every bit alone. A design that decoded the index modulo 32 or ignored the group would clear the wrong sources.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;

  localparam int unsigned GRP_W = 32;

  typedef enum logic [2:0] {
    OP_NONE      = 3'd0,
    OP_PEND_ACK  = 3'd1,
    OP_EN_SET    = 3'd2,
    OP_EN_CLR    = 3'd3,
    OP_PEND_WIPE = 3'd4,
    OP_EN_WIPE   = 3'd5,
    OP_POL_LOAD  = 3'd6,
    OP_KIND_LOAD = 3'd7
  } op_e;

  // group holding a source number
  function automatic int unsigned grp_of(input int unsigned n);
    return n / GRP_W;
  endfunction

  // bit lane of a source number inside its group
  function automatic int unsigned lane_of(input int unsigned n);
    return n % GRP_W;
  endfunction

  // level match: input equals the selected active level
  function automatic logic level_hit(input logic pol, input logic s);
    return ~(pol ^ s);
  endfunction

endpackage

// File: rtl/irqcap_sync.sv
module irqcap_sync #(
  parameter int unsigned W      = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irqcap_detect.sv
module irqcap_detect
  import irqcap_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sig_i,
  input  logic [NUM_SRC-1:0] pol_i,
  input  logic [NUM_SRC-1:0] kind_i,
  output logic [NUM_SRC-1:0] cap_o,
  output logic [NUM_SRC-1:0] lvl_act_o
);

  logic [NUM_SRC-1:0] prev_q;
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_i;
  end

  assign rise_w = sig_i & ~prev_q;
  assign fall_w = ~sig_i & prev_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign lvl_act_o[i] = level_hit(pol_i[i], sig_i[i]);
    assign cap_o[i]     = kind_i[i] ? (pol_i[i] ? rise_w[i] : fall_w[i])
                                    : lvl_act_o[i];
  end

  // R2/R3: an edge source cannot capture in two consecutive cycles
  assert_edge_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(kind_i) && $stable(pol_i)) |->
      ((cap_o & $past(cap_o) & kind_i) == '0));

endmodule

// File: rtl/irqcap_cfg.sv
module irqcap_cfg
  import irqcap_pkg::*;
#(
  parameter int unsigned NUM_SRC   = 64,
  parameter int unsigned GRP_IDX_W = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           wr_op,
  input  logic [GRP_IDX_W-1:0] wr_grp,
  input  logic [31:0]          wr_data,
  output logic [NUM_SRC-1:0]   pol_o,
  output logic [NUM_SRC-1:0]   kind_o,
  output logic [NUM_SRC-1:0]   pend_clr_o,
  output logic [NUM_SRC-1:0]   en_set_o,
  output logic [NUM_SRC-1:0]   en_clr_o
);

  op_e  op;
  logic idx_op;
  logic idx_valid;

  assign op        = op_e'(wr_op);
  assign idx_op    = (op == OP_PEND_ACK) || (op == OP_EN_SET) || (op == OP_EN_CLR);
  assign idx_valid = (wr_data < 32'(NUM_SRC));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned G = grp_of(i);
    localparam int unsigned L = lane_of(i);
    logic sel_idx;
    logic sel_mask;

    assign sel_idx  = (wr_data == 32'(i));
    assign sel_mask = (wr_grp == GRP_IDX_W'(G)) && wr_data[L];

    assign pend_clr_o[i] = wr_en && (((op == OP_PEND_ACK) && sel_idx) ||
                                     ((op == OP_PEND_WIPE) && sel_mask));
    assign en_set_o[i]   = wr_en && (op == OP_EN_SET) && sel_idx;
    assign en_clr_o[i]   = wr_en && (((op == OP_EN_CLR) && sel_idx) ||
                                     ((op == OP_EN_WIPE) && sel_mask));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pol_o[i]  <= 1'b0;
        kind_o[i] <= 1'b0;
      end else if (wr_en && (wr_grp == GRP_IDX_W'(G))) begin
        if (op == OP_POL_LOAD)  pol_o[i]  <= wr_data[L];
        if (op == OP_KIND_LOAD) kind_o[i] <= wr_data[L];
      end
    end
  end

  // R8: an index write touches at most one enable bit
  assert_idx_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx_op) |-> ($onehot0(en_set_o) && $onehot0(en_clr_o) && $onehot0(pend_clr_o)));

  // R11: out-of-range index and the no-op code change nothing
  assert_range_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((idx_op && !idx_valid) || (op == OP_NONE))) |->
      ((en_set_o | en_clr_o | pend_clr_o) == '0));

  // R13: a group load of bit 0 lands in source 0
  assert_pol_load_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (op == OP_POL_LOAD) && (wr_grp == '0)) |=> (pol_o[0] == $past(wr_data[0])));

endmodule

// File: rtl/irq_src_capture.sv
module irq_src_capture
  import irqcap_pkg::*;
#(
  parameter  int unsigned NUM_SRC     = 64,
  parameter  int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_GRP     = (NUM_SRC + GRP_W - 1) / GRP_W,
  localparam int unsigned GRP_IDX_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_i,
  input  logic                 wr_en,
  input  logic [2:0]           wr_op,
  input  logic [GRP_IDX_W-1:0] wr_grp,
  input  logic [31:0]          wr_data,
  output logic [NUM_SRC-1:0]   pend_o,
  output logic [NUM_SRC-1:0]   en_o,
  output logic [NUM_SRC-1:0]   active_o
);

  logic [NUM_SRC-1:0] sig_w;
  logic [NUM_SRC-1:0] pol_w;
  logic [NUM_SRC-1:0] kind_w;
  logic [NUM_SRC-1:0] cap_w;
  logic [NUM_SRC-1:0] lvl_act_w;
  logic [NUM_SRC-1:0] pend_clr_w;
  logic [NUM_SRC-1:0] en_set_w;
  logic [NUM_SRC-1:0] en_clr_w;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] en_q;

  irqcap_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (src_i),
    .dout (sig_w)
  );

  irqcap_cfg #(.NUM_SRC(NUM_SRC), .GRP_IDX_W(GRP_IDX_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_op     (wr_op),
    .wr_grp    (wr_grp),
    .wr_data   (wr_data),
    .pol_o     (pol_w),
    .kind_o    (kind_w),
    .pend_clr_o(pend_clr_w),
    .en_set_o  (en_set_w),
    .en_clr_o  (en_clr_w)
  );

  irqcap_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_i    (sig_w),
    .pol_i    (pol_w),
    .kind_i   (kind_w),
    .cap_o    (cap_w),
    .lvl_act_o(lvl_act_w)
  );

  // capture is ORed in after the clear, so a same-cycle event survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= cap_w | (pend_q & ~pend_clr_w);
      en_q   <= (en_q | en_set_w) & ~en_clr_w;
    end
  end

  assign pend_o   = pend_q;
  assign en_o     = en_q;
  assign active_o = pend_q & en_q;

  // R10: capture and clear together leave the bit set
  assert_capture_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cap_w & pend_clr_w)) |=>
      ((pend_q & $past(cap_w & pend_clr_w)) == $past(cap_w & pend_clr_w)));

  // R7: a clear without a capture empties the bit
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_clr_w & ~cap_w)) |=> ((pend_q & $past(pend_clr_w & ~cap_w)) == '0));

  // R6: an active level source is pending on the next edge
  assert_level_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lvl_act_w & ~kind_w)) |=>
      ((pend_q & $past(lvl_act_w & ~kind_w)) == $past(lvl_act_w & ~kind_w)));

  // R2: no pending bit rises without a capture
  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(cap_w)) == '0));

  // R8: an index set turns the enable on
  assert_enable_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|en_set_w) |=> ((en_q & $past(en_set_w)) == $past(en_set_w)));

endmodule

// File: tb/irq_src_capture_test.sv
`timescale 1ns/1ps
module irq_src_capture_test;

  localparam logic [2:0] OP_NONE = 3'd0, OP_ACK = 3'd1, OP_ESET = 3'd2, OP_ECLR = 3'd3,
                         OP_PWIPE = 3'd4, OP_EWIPE = 3'd5, OP_POL = 3'd6, OP_KIND = 3'd7;

  typedef struct packed {
    logic       pol;
    logic       kind;
    logic       init;
    logic       fin;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd2},  // R2 rising edge captured
    '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 falling ignored
    '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 steady high ignored
    '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3},  // R3 falling captured
    '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},  // R3 rising ignored
    '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd4},  // R4 high level captured
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 low ignored
    '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5},  // R5 low level captured
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5}   // R5 high ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = ~(64'd1 << 6);
  logic        wr_en = 1'b0;
  logic [2:0]  wr_op = 3'd0;
  logic [0:0]  wr_grp = 1'b0;
  logic [31:0] wr_data = '0;
  logic [63:0] pend, en, act;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_src_capture uut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .wr_en(wr_en), .wr_op(wr_op),
    .wr_grp(wr_grp), .wr_data(wr_data), .pend_o(pend), .en_o(en), .active_o(act)
  );

  function automatic logic [63:0] b(input int n);
    return 64'd1 << n;
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; the write takes effect on the following posedge
  task automatic wr(input logic [2:0] op, input logic g, input logic [31:0] d);
    wr_en = 1'b1; wr_op = op; wr_grp = g; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_op = OP_NONE; wr_data = '0;
  endtask

  initial begin
    idle(3);
    chk("R1 pending in reset", pend, '0);
    chk("R1 enable in reset", en, '0);
    chk("R1 active in reset", act, '0);
    rst_n = 1'b1;
    idle(4);
    chk("R1 zero config is active-low level, all pending", pend, '1);
    wr(OP_PWIPE, 1'b0, '1);
    wr(OP_PWIPE, 1'b1, '1);
    chk("R9 pending wipe leaves only active level source 6", pend, b(6));
    src[6] = 1'b1;
    idle(4);
    wr(OP_ACK, 1'b0, 32'd6);
    chk("R6 ack after level goes inactive", pend, '0);

    // table walk on source 5; configuration through R13 loads
    for (int k = 0; k < NV; k++) begin
      src[5] = TBL[k].init;
      idle(4);
      wr(OP_POL, 1'b0, 32'(TBL[k].pol) << 5);
      wr(OP_KIND, 1'b0, 32'(TBL[k].kind) << 5);
      idle(2);
      wr(OP_ACK, 1'b0, 32'd5);
      src[5] = TBL[k].fin;
      idle(5);
      chk($sformatf("R%0d row %0d (config via R13)", TBL[k].req, k), pend, 64'(TBL[k].exp) << 5);
    end

    // R12: latency, rising edge on source 5
    wr(OP_POL, 1'b0, 32'd1 << 5);
    wr(OP_KIND, 1'b0, 32'd1 << 5);
    src[5] = 1'b0;
    idle(4);
    wr(OP_ACK, 1'b0, 32'd5);
    src[5] = 1'b1;
    idle(2);
    chk("R12 not yet pending after two edges", pend, '0);
    idle(1);
    chk("R12 pending after third edge", pend, b(5));

    // R8: index enable set/clear and the active vector
    wr(OP_ESET, 1'b1, 32'd5);
    chk("R8 enable set by index", en, b(5));
    chk("R8 active is pending and enabled", act, b(5));
    wr(OP_ESET, 1'b0, 32'd40);
    chk("R8 second enable", en, b(5) | b(40));
    chk("R8 active without pending", act, b(5));
    wr(OP_ECLR, 1'b0, 32'd5);
    chk("R8 enable clear by index", en, b(40));
    chk("R8 active after disable", act, '0);

    // R7: acknowledge clears one bit only
    src[33] = 1'b0; src[34] = 1'b0;
    idle(4);
    src[33] = 1'b1; src[34] = 1'b1;
    idle(4);
    chk("R7 level pulses latched", pend, b(5) | b(33) | b(34));
    wr(OP_ACK, 1'b0, 32'd33);
    chk("R7 ack source 33 only", pend, b(5) | b(34));
    wr(OP_ACK, 1'b0, 32'd5);
    chk("R7 ack source 5 only", pend, b(34));

    // R11: out-of-range and no-op writes
    wr(OP_ESET, 1'b0, 32'd64);
    chk("R11 enable index 64 ignored", en, b(40));
    wr(OP_ACK, 1'b0, 32'd100);
    chk("R11 ack index 100 ignored", pend, b(34));
    wr(OP_NONE, 1'b1, '1);
    chk("R11 op 0 leaves enables", en, b(40));
    chk("R11 op 0 leaves pending", pend, b(34));

    // R9: group wipes
    wr(OP_ESET, 1'b0, 32'd41);
    wr(OP_ESET, 1'b0, 32'd3);
    wr(OP_EWIPE, 1'b1, 32'd1 << 8);
    chk("R9 enable wipe group 1 bit 8", en, b(3) | b(41));
    wr(OP_EWIPE, 1'b0, 32'd1 << 9);
    chk("R9 enable wipe other group leaves 41", en, b(3) | b(41));
    wr(OP_PWIPE, 1'b1, 32'd1 << 2);
    chk("R9 pending wipe group 1 bit 2", pend, '0);

    // R6: ack while level is active does not stick
    src[33] = 1'b0;
    idle(4);
    chk("R6 level active pending", pend, b(33));
    wr(OP_ACK, 1'b0, 32'd33);
    idle(1);
    chk("R6 ack ignored while active", pend, b(33));
    src[33] = 1'b1;
    idle(4);
    chk("R6 stays latched when inactive", pend, b(33));
    wr(OP_ACK, 1'b0, 32'd33);
    chk("R6 ack clears when inactive", pend, '0);

    // R10: capture and ack on the same edge
    src[5] = 1'b0;
    idle(4);
    wr(OP_ACK, 1'b0, 32'd5);
    chk("R10 no capture on falling for rising source", pend, '0);
    src[5] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(OP_ACK, 1'b0, 32'd5);
    chk("R10 capture wins over same-cycle ack", pend, b(5));
    wr(OP_ACK, 1'b0, 32'd5);
    chk("R10 later ack clears", pend, '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule